// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets a processor reach the management registers of an Ethernet PHY through two 16-bit registers. One holds data. The other is a command word carrying a direction flag, a 5-bit PHY address and a 5-bit register number. Writing the command word while the engine is idle starts one clause-22 management frame on the MDC/MDIO pair. The engine builds the serial clock, shifts the frame out, turns the data pin around for reads and collects the PHY's answer.

Software first loads the data register when it wants a write. It then writes the command word and polls the finish bit in the command register. That bit is low while a frame is on the wire and high again once the frame is over. After a read, the data register holds the 16 bits returned by the PHY. The MDC frequency is the system clock divided by the even parameter `CLK_DIV`. The default of 40 gives 2.5 MHz from a 100 MHz clock.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command register reads 16'h8000 (finish bit 15 set, all fields zero), the data register reads 0, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: MDC toggles every `CLK_DIV/2` system clock cycles, so each high and each low phase lasts exactly `CLK_DIV/2` cycles.
- R3: In the command word, bit 13 = 1 selects a write and 0 a read, bits 12:8 are the PHY address and bits 4:0 the register number. Bits 15:14 and 7:5 are ignored: they do not reach the frame and read back as 0. The register reads back as {finish, 0, dir, phy[4:0], 3'b000, regnum[4:0]}.
- R4: Every frame starts with 32 ones, then start bits 0,1, then opcode 0,1 for a write or 1,0 for a read, then the PHY address and then the register number, each MSB first. MDIO is driven throughout this header.
- R5: In a write frame the engine drives turnaround bits 1,0 and then the 16 bits of the data register, MSB first, keeping MDIO driven to the end of the frame.
- R6: In a read frame MDIO is released for the two turnaround bits and the 16 data bits. The input is sampled on rising MDC edges, MSB first. At the end of the frame the 16 sampled bits appear in the data register.
- R7: The finish bit reads 0 from the cycle after an accepted command write until the frame ends, and then returns to 1 on the same system clock edge that lowers MDC after the last bit.
- R8: While a frame is in progress, writes to the command register and to the data register are ignored. The frame on the wire and both read-back values are unaffected.
- R9: `mdio_o` and `mdio_oe` change only on system clock edges where MDC falls, so they are stable around every rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 command word, 1 data register |
| reg_wdata | input | 16 | Write data |
| ctrl_rdata | output | 16 | Command register read-back, bit 15 is the finish flag |
| data_rdata | output | 16 | Data register read-back |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The bench runs a behavioural PHY. It captures every bit on rising MDC and answers reads on falling MDC. Directed frames use all-ones and all-zero addresses and data to catch stuck or swapped address bits, and a data pattern of alternating nibbles to catch bit reversal in the read path. Command words with the unused bits set show whether those bits leak into the frame. A second command and a data write issued in the middle of a frame show whether the engine ignores them while busy. Seeded random commands then mix directions, addresses and data so that errors in opcode choice and turnaround release are separated from errors in field shifting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN);
  // bit positions of the command word
  localparam int unsigned DIR_BIT  = 13;
  localparam int unsigned PHY_LSB  = 8;
  localparam int unsigned REG_LSB  = 0;
  localparam int unsigned FIN_BIT  = 15;
  // first bit index of turnaround and of data inside a frame
  localparam int unsigned TA_IDX   = 46;
  localparam int unsigned DAT_IDX  = 48;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regnum;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  assign rise_tick = (cnt_q == CNT_W'(HALF - 1));
  assign fall_tick = (cnt_q == CNT_W'(CLK_DIV - 1));

  always_comb begin
    cnt_d = fall_tick ? '0 : cnt_q + 1'b1;
    mdc_d = mdc_q;
    if (rise_tick) mdc_d = 1'b1;
    if (fall_tick) mdc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [WORD_W-1:0] rd_value,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] ctrl_rdata
);
  mdio_cmd_t         cmd_q, cmd_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              cmd_en, data_en;

  assign start   = reg_wr && !reg_sel && !busy;
  assign cmd_en  = start;
  assign data_en = (reg_wr && reg_sel && !busy) || rd_load;

  always_comb begin
    cmd_d        = cmd_q;
    cmd_d.wr     = reg_wdata[DIR_BIT];
    cmd_d.phy    = reg_wdata[PHY_LSB +: ADDR_W];
    cmd_d.regnum = reg_wdata[REG_LSB +: ADDR_W];
    data_d       = rd_load ? rd_value : reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign cmd  = cmd_q;
  assign data = data_q;
  assign ctrl_rdata = {~busy, 1'b0, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regnum};
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int unsigned TAIL_W = FRAME_LEN - PRE_LEN;

  logic              busy_q, busy_d;
  logic              run_q, run_d;
  logic              wr_q, wr_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_nx;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              mdo_q, mdo_d;
  logic              oe_q, oe_d;
  logic              last_bit, sample;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign idx_nx   = idx_q + 1'b1;
  assign done     = busy_q && run_q && fall_tick && last_bit;
  assign sample   = busy_q && run_q && rise_tick && !wr_q
                    && (idx_q >= IDX_W'(DAT_IDX));

  function automatic logic bit_at(input logic [IDX_W-1:0] i,
                                  input logic [TAIL_W-1:0] t);
    logic [IDX_W-2:0] k;
    k = i[IDX_W-2:0];
    return i[IDX_W-1] ? t[~k] : 1'b1;
  endfunction

  always_comb begin
    busy_d = busy_q;
    run_d  = run_q;
    wr_d   = wr_q;
    idx_d  = idx_q;
    tail_d = tail_q;
    rx_d   = rx_q;
    mdo_d  = mdo_q;
    oe_d   = oe_q;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      run_d  = 1'b0;
      wr_d   = cmd.wr;
      idx_d  = '0;
      tail_d = {2'b01, cmd.wr ? 2'b01 : 2'b10, cmd.phy, cmd.regnum,
                cmd.wr ? 2'b10 : 2'b00, cmd.wr ? tx_data : {WORD_W{1'b0}}};
    end else if (busy_q && fall_tick) begin
      if (!run_q) begin
        run_d = 1'b1;
        mdo_d = bit_at('0, tail_q);
        oe_d  = 1'b1;
      end else if (last_bit) begin
        busy_d = 1'b0;
        run_d  = 1'b0;
        mdo_d  = 1'b0;
        oe_d   = 1'b0;
      end else begin
        idx_d = idx_nx;
        mdo_d = wr_q ? bit_at(idx_nx, tail_q)
                     : (idx_nx < IDX_W'(TA_IDX)) && bit_at(idx_nx, tail_q);
        oe_d  = wr_q || (idx_nx < IDX_W'(TA_IDX));
      end
    end
    if (sample) rx_d = {rx_q[WORD_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      tail_q <= '0;
      rx_q   <= '0;
      mdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      run_q  <= run_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      tail_q <= tail_d;
      rx_q   <= rx_d;
      mdo_q  <= mdo_d;
      oe_q   <= oe_d;
    end
  end

  assign busy    = busy_q;
  assign rx_data = rx_d;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              rise_tick, fall_tick;
  logic              busy, done, start;
  mdio_cmd_t         cmd;
  logic [WORD_W-1:0] data, rx_data;

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .rd_load    (done && !cmd.wr),
    .rd_value   (rx_data),
    .start      (start),
    .cmd        (cmd),
    .data       (data),
    .ctrl_rdata (ctrl_rdata)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd_from_bus(reg_wdata)),
    .tx_data   (data),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  function automatic mdio_cmd_t cmd_from_bus(input logic [WORD_W-1:0] w);
    mdio_cmd_t c;
    c.wr     = w[DIR_BIT];
    c.phy    = w[PHY_LSB +: ADDR_W];
    c.regnum = w[REG_LSB +: ADDR_W];
    return c;
  endfunction

  assign data_rdata = data;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [15:0] ctrl_rdata,
  input logic [15:0] data_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !ctrl_rdata[15]);  // R7

  AST_FIN_ON_MDC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rdata[15]) |-> $fell(mdc));  // R7

  AST_CMD_WR_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !ctrl_rdata[15]) |=> $stable(ctrl_rdata[13:0]));  // R8

  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[15] && $past(!ctrl_rdata[15])) |-> $stable(data_rdata));  // R8

  AST_MDO_ON_MDC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));  // R9
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .ctrl_rdata (ctrl_rdata),
  .data_rdata (data_rdata),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int DIV  = 40;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int checks = 0;
  int failures = 0;
  int r2_bad = 0;
  int r9_bad = 0;
  bit finished = 1'b0;

  mdio_cmd_engine #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 / R9 monitor sampled away from the active edge
  logic prev_mdc, prev_o, prev_oe, mon_seen;
  int   run_len;
  initial begin
    mon_seen = 1'b0; run_len = 0;
    prev_mdc = 1'b0; prev_o = 1'b0; prev_oe = 1'b0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (mdc === prev_mdc) run_len++;
      else begin
        if (mon_seen && run_len != HALF) r2_bad++;
        mon_seen = 1'b1;
        run_len = 1;
      end
      if ((mdio_o !== prev_o || mdio_oe !== prev_oe) &&
          !(prev_mdc === 1'b1 && mdc === 1'b0)) r9_bad++;
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end
  end

  task automatic bus_wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
            wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
  endfunction

  task automatic run_cmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wdat, input logic [15:0] rdval,
                         input logic [15:0] junk, input bit poke_busy);
    logic [63:0] cap_o, cap_oe, ef;
    logic [15:0] cw;
    int wait_n;
    ef = exp_frame(wr, phy, rg, wdat);
    cw = junk | {2'b00, wr, phy, 3'b000, rg};
    bus_wr(1'b1, wdat);
    bus_wr(1'b0, cw);
    chk(ctrl_rdata[15] == 1'b0, "R7 finish low after command", 64'(ctrl_rdata[15]), 64'd0);
    wait (mdio_oe === 1'b1);
    if (poke_busy) begin
      bus_wr(1'b0, ~cw);
      bus_wr(1'b1, ~wdat);
    end
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
      if (!wr && k >= 47 && k < 63) begin
        @(negedge mdc);
        mdio_i = rdval[15-(k-47)];
      end
    end
    chk(cap_o[63:18] == ef[63:18] && &cap_oe[63:18], "R4 header bits",
        cap_o, ef);
    if (wr)
      chk(cap_o[17:0] == ef[17:0] && &cap_oe[17:0], "R5 write turnaround and data",
          {cap_oe[17:0], cap_o[17:0]}, {18'h3FFFF, ef[17:0]});
    else
      chk(cap_oe[17:0] == 18'h0, "R6 read releases MDIO", 64'(cap_oe[17:0]), 64'd0);
    wait_n = 0;
    @(negedge clk);
    while (!ctrl_rdata[15] && wait_n < 4 * DIV) begin
      @(negedge clk);
      wait_n++;
    end
    chk(ctrl_rdata[15] == 1'b1 && wait_n <= HALF, "R7 finish returns after frame",
        64'(wait_n), 64'(HALF));
    chk(ctrl_rdata == {1'b1, 1'b0, wr, phy, 3'b000, rg},
        poke_busy ? "R8 command readback after busy write" : "R3 command readback",
        64'(ctrl_rdata), 64'({1'b1, 1'b0, wr, phy, 3'b000, rg}));
    chk(data_rdata == (wr ? wdat : rdval),
        poke_busy ? "R8 data register after busy write"
                  : (wr ? "R5 data register kept" : "R6 read data loaded"),
        64'(data_rdata), 64'(wr ? wdat : rdval));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ctrl_rdata == 16'h8000 && data_rdata == 16'h0 && mdio_oe == 1'b0 && mdc == 1'b0,
        "R1 state in reset", {ctrl_rdata, data_rdata, 30'd0, mdio_oe, mdc},
        {16'h8000, 16'h0000, 32'd0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctrl_rdata == 16'h8000 && data_rdata == 16'h0 && mdio_oe == 1'b0,
        "R1 state after reset release", {ctrl_rdata, data_rdata}, {16'h8000, 16'h0000});

    // directed corners
    run_cmd(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 16'h0000, 1'b0);
    run_cmd(1'b0, 5'h00, 5'h00, 16'h1234, 16'h0000, 16'h0000, 1'b0);
    run_cmd(1'b0, 5'h15, 5'h0A, 16'h0000, 16'hA5C3, 16'h0000, 1'b0);
    run_cmd(1'b1, 5'h01, 5'h10, 16'h8001, 16'h0000, 16'h0000, 1'b0);
    // unused bits set: R3
    run_cmd(1'b1, 5'h0A, 5'h15, 16'h5A0F, 16'h0000, 16'hC0E0, 1'b0);
    run_cmd(1'b0, 5'h11, 5'h03, 16'h0000, 16'h3C96, 16'hC0E0, 1'b0);
    // writes during a frame: R8
    run_cmd(1'b1, 5'h06, 5'h09, 16'h0F0F, 16'h0000, 16'h0000, 1'b1);
    run_cmd(1'b0, 5'h19, 5'h1C, 16'h0000, 16'h6E21, 16'h0000, 1'b1);

    // seeded random commands
    for (int n = 0; n < 10; n++) begin
      logic        rw;
      logic [4:0]  rp, rr;
      logic [15:0] rd, rv;
      rw = 1'($urandom);
      rp = 5'($urandom);
      rr = 5'($urandom);
      rd = 16'($urandom);
      rv = 16'($urandom);
      run_cmd(rw, rp, rr, rd, rv, 16'h0000, 1'($urandom_range(0, 3) == 0));
    end

    chk(r2_bad == 0, "R2 MDC phase length", 64'(r2_bad), 64'd0);
    chk(r9_bad == 0, "R9 MDIO changes only on MDC fall", 64'(r9_bad), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule